// File: doc/BRIEF.md
# Radix-4 Butterfly Processing Element with Twiddle Multipliers

This block is the arithmetic heart of one stage of a radix-4 fast Fourier transform. On every clock where the input is marked valid it takes four complex fixed-point samples side by side. It forms their 4-point DFT in two registered adder stages. It then rotates legs 1, 2 and 3 by twiddle factors drawn from a built-in constant table. Four complex results leave together, and a new group can enter on every clock.

An external sequencer drives a twiddle index `k` alongside each group. Leg `m` is rotated by W^(m·k mod N), where W = e^(−2jπ/N). For the final FFT stage, where no rotation is wanted, the sequencer raises the bypass input with the group. The results then leave one cycle earlier and skip the multipliers entirely. Output selection is decided each cycle among four named conditions:

- SEL_IDLE: nothing is ready.
- SEL_TWID: only a rotated group is ready.
- SEL_BYPASS: only a bypassed group is ready.
- SEL_CLASH: both are ready in the same cycle.

The condition is re-evaluated every clock. Any condition can follow any other, depending purely on which pipeline slots hold valid data.

Top module: `r4_pe_twiddle`

## Requirements
- R1: All four legs are captured on one clock while `in_valid` is high. Output leg 0 equals x0+x1+x2+x3 (packed index 0 of `in_re`/`in_im` is x0, index 3 is x3).
- R2: Output legs 1, 2 and 3 are computed before any rotation as follows: leg 1 = (x0−x2) − j(x1−x3); leg 2 = (x0+x2) − (x1+x3); leg 3 = (x0−x2) + j(x1−x3).
- R3: A group entered with `in_bypass` high appears on the outputs, unrotated, with `out_valid` high exactly 2 clocks after it is captured.
- R4: A group entered with `in_bypass` low appears exactly 3 clocks after capture, and leg 0 is never scaled.
- R5: For a non-bypassed group, leg m (m = 1, 2, 3) is multiplied by the table entry for exponent e = m·k mod N. The entry's real part is round(cos(2πe/N)·2^(CW−1)) and its imaginary part is round(−sin(2πe/N)·2^(CW−1)). Both are clipped to at most 2^(CW−1)−1. Each complex product component is shifted right arithmetically by CW−1 bits, and its low OW bits are kept.
- R6: A leg whose exponent is 0 passes through the rotation stage unchanged.
- R7: Outputs are OW = DW+2 bits wide, and the adder stages never truncate or wrap, even at full-scale inputs.
- R8: When a rotated group and a bypassed group that entered one clock later arrive in the same cycle, the rotated group is delivered and the bypassed group is discarded.
- R9: After reset, and on every clock that has no group due, `out_valid` is low and all output words are zero.
- R10: Groups entered on consecutive clocks each emerge on consecutive clocks with no gaps and no mixing of legs.
- R11: The twiddle index and bypass flag are sampled with their group. Values on those inputs on other clocks do not affect that group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a group of four samples on this clock |
| in_bypass | input | 1 | Skip the twiddle rotation for this group |
| in_twidx | input | KW = log2(N) | Twiddle index k for this group |
| in_re | input | 4 × DW | Real parts, legs 0..3 |
| in_im | input | 4 × DW | Imaginary parts, legs 0..3 |
| out_valid | output | 1 | Marks a result group |
| out_re | output | 4 × OW | Real parts of results, legs 0..3 |
| out_im | output | 4 × OW | Imaginary parts of results, legs 0..3 |

## Verification
Two outcomes can land on the output in the same cycle. A rotated group finishes its third stage while a bypassed group, entered one clock later, finishes its second. The bench provokes this by entering a non-bypassed group followed immediately by a bypassed one, in isolation and inside a mixed stream. Its model places each group at its own latency. When two groups claim the same slot, the model keeps the rotated one. The bench then checks that exactly one valid output appears in that slot, that it carries the rotated values, and that the dropped group never appears on a later clock.

// File: rtl/r4_pkg.sv
package r4_pkg;

    typedef enum logic [1:0] {
        SEL_IDLE,
        SEL_TWID,
        SEL_BYPASS,
        SEL_CLASH
    } out_sel_e;

    localparam longint Q_ONE   = 64'sd1073741824;
    localparam longint PI_Q30  = 64'sd3373259426;
    localparam int     TAYLOR_TERMS = 10;

    function automatic longint cos_q30(longint x);
        longint x2;
        longint term;
        longint acc;
        x2   = (x * x) >>> 30;
        term = Q_ONE;
        acc  = Q_ONE;
        for (int i = 1; i <= TAYLOR_TERMS; i++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * i - 1) * (2 * i)));
            acc  = acc + term;
        end
        return acc;
    endfunction

    function automatic longint sin_q30(longint x);
        longint x2;
        longint term;
        longint acc;
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int i = 1; i <= TAYLOR_TERMS; i++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * i) * (2 * i + 1)));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Rounded, clipped twiddle component for exponent e of an n-point transform.
    function automatic longint tw_value(int e, int n, int cw, bit want_im);
        int     quarter;
        int     em;
        int     quad;
        int     rem;
        longint x;
        longint c;
        longint s;
        longint cv;
        longint sv;
        longint v;
        longint scaled;
        longint top;
        quarter = n / 4;
        em      = e % n;
        quad    = em / quarter;
        rem     = em % quarter;
        x       = (2 * PI_Q30 * longint'(rem)) / longint'(n);
        c       = cos_q30(x);
        s       = sin_q30(x);
        case (quad)
            0:       begin cv =  c; sv =  s; end
            1:       begin cv = -s; sv =  c; end
            2:       begin cv = -c; sv = -s; end
            default: begin cv =  s; sv = -c; end
        endcase
        v      = want_im ? -sv : cv;
        scaled = (v * (longint'(1) << (cw - 1)) + (longint'(1) << 29)) >>> 30;
        top    = (longint'(1) << (cw - 1)) - 1;
        if (scaled > top) scaled = top;
        return scaled;
    endfunction

endpackage

// File: rtl/r4_bfly_core.sv
module r4_bfly_core #(
    parameter int DW = 12,
    parameter int KW = 6,
    localparam int SW = DW + 1,
    localparam int OW = DW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_bypass,
    input  logic [KW-1:0]       in_twidx,
    input  logic [3:0][DW-1:0]  in_re,
    input  logic [3:0][DW-1:0]  in_im,
    output logic                s2_valid,
    output logic                s2_bypass,
    output logic [KW-1:0]       s2_twidx,
    output logic [3:0][OW-1:0]  s2_re,
    output logic [3:0][OW-1:0]  s2_im
);

    // Stage 1 partial sums: [0]=x0+x2, [1]=x0-x2, [2]=x1+x3, [3]=x1-x3
    logic [3:0][SW-1:0] p_re_n, p_im_n;
    logic [3:0][SW-1:0] p_re, p_im;
    logic               s1_valid, s1_bypass;
    logic [KW-1:0]      s1_twidx;
    logic [3:0][OW-1:0] q_re_n, q_im_n;

    always_comb begin
        p_re_n[0] = SW'($signed(in_re[0])) + SW'($signed(in_re[2]));
        p_re_n[1] = SW'($signed(in_re[0])) - SW'($signed(in_re[2]));
        p_re_n[2] = SW'($signed(in_re[1])) + SW'($signed(in_re[3]));
        p_re_n[3] = SW'($signed(in_re[1])) - SW'($signed(in_re[3]));
        p_im_n[0] = SW'($signed(in_im[0])) + SW'($signed(in_im[2]));
        p_im_n[1] = SW'($signed(in_im[0])) - SW'($signed(in_im[2]));
        p_im_n[2] = SW'($signed(in_im[1])) + SW'($signed(in_im[3]));
        p_im_n[3] = SW'($signed(in_im[1])) - SW'($signed(in_im[3]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_bypass <= 1'b0;
            s1_twidx  <= '0;
            p_re      <= '0;
            p_im      <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_bypass <= in_bypass;
                s1_twidx  <= in_twidx;
                p_re      <= p_re_n;
                p_im      <= p_im_n;
            end
        end
    end

    // Stage 2: the +/-j rotations are swaps with one negation.
    always_comb begin
        q_re_n[0] = OW'($signed(p_re[0])) + OW'($signed(p_re[2]));
        q_im_n[0] = OW'($signed(p_im[0])) + OW'($signed(p_im[2]));
        q_re_n[2] = OW'($signed(p_re[0])) - OW'($signed(p_re[2]));
        q_im_n[2] = OW'($signed(p_im[0])) - OW'($signed(p_im[2]));
        q_re_n[1] = OW'($signed(p_re[1])) + OW'($signed(p_im[3]));
        q_im_n[1] = OW'($signed(p_im[1])) - OW'($signed(p_re[3]));
        q_re_n[3] = OW'($signed(p_re[1])) - OW'($signed(p_im[3]));
        q_im_n[3] = OW'($signed(p_im[1])) + OW'($signed(p_re[3]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_bypass <= 1'b0;
            s2_twidx  <= '0;
            s2_re     <= '0;
            s2_im     <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_bypass <= s1_bypass;
                s2_twidx  <= s1_twidx;
                s2_re     <= q_re_n;
                s2_im     <= q_im_n;
            end
        end
    end

    // R10: every accepted group reaches the second adder stage two clocks later
    a_r10_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 s2_valid);

endmodule

// File: rtl/r4_twiddle_rom.sv
module r4_twiddle_rom #(
    parameter int N     = 64,
    parameter int CW    = 12,
    parameter int PORTS = 3,
    localparam int KW   = $clog2(N)
) (
    input  logic [PORTS-1:0][KW-1:0] rd_exp,
    output logic [PORTS-1:0][CW-1:0] rd_re,
    output logic [PORTS-1:0][CW-1:0] rd_im
);

    logic [CW-1:0] tab_re [N];
    logic [CW-1:0] tab_im [N];

    for (genvar e = 0; e < N; e++) begin : g_entry
        localparam longint VRE = r4_pkg::tw_value(e, N, CW, 1'b0);
        localparam longint VIM = r4_pkg::tw_value(e, N, CW, 1'b1);
        assign tab_re[e] = CW'(VRE);
        assign tab_im[e] = CW'(VIM);
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign rd_re[p] = tab_re[rd_exp[p]];
        assign rd_im[p] = tab_im[rd_exp[p]];
    end

endmodule

// File: rtl/r4_cmul.sv
module r4_cmul #(
    parameter int OW = 14,
    parameter int CW = 12,
    localparam int PW = OW + CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          exp_zero,
    input  logic [OW-1:0] a_re,
    input  logic [OW-1:0] a_im,
    input  logic [CW-1:0] w_re,
    input  logic [CW-1:0] w_im,
    output logic [OW-1:0] y_re,
    output logic [OW-1:0] y_im
);

    logic signed [PW-1:0] prod_re, prod_im;
    logic signed [PW-1:0] shr_re, shr_im;
    logic [OW-1:0]        nxt_re, nxt_im;

    always_comb begin
        prod_re = PW'($signed(a_re)) * PW'($signed(w_re))
                - PW'($signed(a_im)) * PW'($signed(w_im));
        prod_im = PW'($signed(a_re)) * PW'($signed(w_im))
                + PW'($signed(a_im)) * PW'($signed(w_re));
        shr_re  = prod_re >>> (CW - 1);
        shr_im  = prod_im >>> (CW - 1);
        if (exp_zero) begin
            nxt_re = a_re;
            nxt_im = a_im;
        end else begin
            nxt_re = shr_re[OW-1:0];
            nxt_im = shr_im[OW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_re <= '0;
            y_im <= '0;
        end else if (en) begin
            y_re <= nxt_re;
            y_im <= nxt_im;
        end
    end

    // R6: exponent zero is an exact identity
    a_r6_unit_leg: assert property (@(posedge clk) disable iff (!rst_n)
        (en && exp_zero) |=> (y_re == $past(a_re)) && (y_im == $past(a_im)));

endmodule

// File: rtl/r4_pe_twiddle.sv
module r4_pe_twiddle #(
    parameter int DW = 12,
    parameter int CW = 12,
    parameter int N  = 64,
    localparam int OW = DW + 2,
    localparam int KW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_bypass,
    input  logic [KW-1:0]       in_twidx,
    input  logic [3:0][DW-1:0]  in_re,
    input  logic [3:0][DW-1:0]  in_im,
    output logic                out_valid,
    output logic [3:0][OW-1:0]  out_re,
    output logic [3:0][OW-1:0]  out_im
);
    import r4_pkg::*;

    localparam int LEGS = 4;

    logic               s2_valid, s2_bypass;
    logic [KW-1:0]      s2_twidx;
    logic [3:0][OW-1:0] s2_re, s2_im;

    r4_bfly_core #(.DW(DW), .KW(KW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bypass (in_bypass),
        .in_twidx  (in_twidx),
        .in_re     (in_re),
        .in_im     (in_im),
        .s2_valid  (s2_valid),
        .s2_bypass (s2_bypass),
        .s2_twidx  (s2_twidx),
        .s2_re     (s2_re),
        .s2_im     (s2_im)
    );

    // Exponents for legs 1..3: k, 2k, 3k modulo N (KW-bit wrap).
    logic               tw_go;
    logic [2:0][KW-1:0] leg_exp;
    logic [2:0][CW-1:0] w_re, w_im;

    always_comb begin
        tw_go      = s2_valid && !s2_bypass;
        leg_exp[0] = s2_twidx;
        leg_exp[1] = {s2_twidx[KW-2:0], 1'b0};
        leg_exp[2] = s2_twidx + {s2_twidx[KW-2:0], 1'b0};
    end

    r4_twiddle_rom #(.N(N), .CW(CW), .PORTS(3)) u_rom (
        .rd_exp (leg_exp),
        .rd_re  (w_re),
        .rd_im  (w_im)
    );

    logic               s3_valid;
    logic [3:0][OW-1:0] s3_re, s3_im;

    for (genvar m = 1; m < LEGS; m++) begin : g_leg
        r4_cmul #(.OW(OW), .CW(CW)) u_cmul (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (tw_go),
            .exp_zero (leg_exp[m-1] == '0),
            .a_re     (s2_re[m]),
            .a_im     (s2_im[m]),
            .w_re     (w_re[m-1]),
            .w_im     (w_im[m-1]),
            .y_re     (s3_re[m]),
            .y_im     (s3_im[m])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s3_valid <= 1'b0;
            s3_re[0] <= '0;
            s3_im[0] <= '0;
        end else begin
            s3_valid <= tw_go;
            if (tw_go) begin
                s3_re[0] <= s2_re[0];
                s3_im[0] <= s2_im[0];
            end
        end
    end

    // Output selection
    out_sel_e sel;
    logic     byp_ready;

    always_comb begin
        byp_ready = s2_valid && s2_bypass;
        unique case ({s3_valid, byp_ready})
            2'b00:   sel = SEL_IDLE;
            2'b10:   sel = SEL_TWID;
            2'b01:   sel = SEL_BYPASS;
            default: sel = SEL_CLASH;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_IDLE: begin
                out_valid = 1'b0;
                out_re    = '0;
                out_im    = '0;
            end
            SEL_BYPASS: begin
                out_valid = 1'b1;
                out_re    = s2_re;
                out_im    = s2_im;
            end
            SEL_TWID, SEL_CLASH: begin
                out_valid = 1'b1;
                out_re    = s3_re;
                out_im    = s3_im;
            end
            default: begin
                out_valid = 1'b0;
                out_re    = '0;
                out_im    = '0;
            end
        endcase
    end

    // Leg-0 reference sum taken straight from the ports, for the checks below.
    logic [OW-1:0] in_sum_re, in_sum_im;
    always_comb begin
        in_sum_re = OW'($signed(in_re[0])) + OW'($signed(in_re[1]))
                  + OW'($signed(in_re[2])) + OW'($signed(in_re[3]));
        in_sum_im = OW'($signed(in_im[0])) + OW'($signed(in_im[1]))
                  + OW'($signed(in_im[2])) + OW'($signed(in_im[3]));
    end

    // R3: bypassed group is out two clocks later
    a_r3_bypass_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bypass) |=> ##1 out_valid);

    // R4: rotated group is out three clocks later
    a_r4_twiddle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_bypass) |=> ##2 out_valid);

    // R1: leg 0 of an uncontested bypassed group is the plain four-way sum
    a_r1_leg0_sum: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && in_bypass, 2) && !$past(in_valid && !in_bypass, 3))
        |-> (out_re[0] == $past(in_sum_re, 2)) && (out_im[0] == $past(in_sum_im, 2)));

    // R9: no output without a group two or three clocks back
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid, 2) && !$past(in_valid && !in_bypass, 3)) |-> !out_valid);

endmodule

// File: tb/r4_pe_twiddle_bench.sv
module r4_pe_twiddle_bench;

    localparam int DW = 12;
    localparam int CW = 12;
    localparam int N  = 64;
    localparam int OW = DW + 2;
    localparam int KW = 6;
    localparam int CLK_PERIOD = 10;
    localparam int MAXS = 40;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_bypass = 1'b0;
    logic [KW-1:0]      in_twidx = '0;
    logic [3:0][DW-1:0] in_re = '0;
    logic [3:0][DW-1:0] in_im = '0;
    logic               out_valid;
    logic [3:0][OW-1:0] out_re, out_im;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    r4_pe_twiddle #(.DW(DW), .CW(CW), .N(N)) u_r4_pe_twiddle (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bypass(in_bypass),
        .in_twidx(in_twidx), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    // Stimulus and expected schedule
    bit  st_v [MAXS];
    bit  st_b [MAXS];
    int  st_k [MAXS];
    int  st_re [MAXS][4];
    int  st_im [MAXS][4];
    bit  ex_v [MAXS + 8];
    longint ex_re [MAXS + 8][4];
    longint ex_im [MAXS + 8][4];

    function automatic longint wrap_ow(longint v);
        logic signed [OW-1:0] t;
        t = v[OW-1:0];
        return longint'(t);
    endfunction

    function automatic longint tw_ref(int e, bit want_im);
        real    a;
        real    f;
        longint v;
        longint top;
        a   = 2.0 * 3.14159265358979323846 * real'(e) / real'(N);
        f   = want_im ? -$sin(a) : $cos(a);
        v   = longint'($floor(f * real'(1 << (CW - 1)) + 0.5));
        top = (longint'(1) << (CW - 1)) - 1;
        if (v > top) v = top;
        return v;
    endfunction

    task automatic expect_group(int i, int slot);
        longint xr[4], xi[4], yr[4], yi[4];
        for (int m = 0; m < 4; m++) begin
            xr[m] = st_re[i][m];
            xi[m] = st_im[i][m];
        end
        yr[0] = xr[0] + xr[1] + xr[2] + xr[3];
        yi[0] = xi[0] + xi[1] + xi[2] + xi[3];
        yr[1] = (xr[0] - xr[2]) + (xi[1] - xi[3]);
        yi[1] = (xi[0] - xi[2]) - (xr[1] - xr[3]);
        yr[2] = (xr[0] + xr[2]) - (xr[1] + xr[3]);
        yi[2] = (xi[0] + xi[2]) - (xi[1] + xi[3]);
        yr[3] = (xr[0] - xr[2]) - (xi[1] - xi[3]);
        yi[3] = (xi[0] - xi[2]) + (xr[1] - xr[3]);
        for (int m = 0; m < 4; m++) begin
            longint wr, wi, pr, pi;
            int e;
            e = (m * st_k[i]) % N;
            if (!st_b[i] && m != 0 && e != 0) begin
                wr = tw_ref(e, 1'b0);
                wi = tw_ref(e, 1'b1);
                pr = yr[m] * wr - yi[m] * wi;
                pi = yr[m] * wi + yi[m] * wr;
                ex_re[slot][m] = wrap_ow(pr >>> (CW - 1));
                ex_im[slot][m] = wrap_ow(pi >>> (CW - 1));
            end else begin
                ex_re[slot][m] = yr[m];
                ex_im[slot][m] = yi[m];
            end
        end
        ex_v[slot] = 1'b1;
    endtask

    task automatic build_expect(int n);
        for (int t = 0; t < MAXS + 8; t++) ex_v[t] = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (st_v[i]) begin
                if (st_b[i]) begin
                    if (!ex_v[i + 2]) expect_group(i, i + 2);
                end else begin
                    expect_group(i, i + 3);
                end
            end
        end
    endtask

    task automatic check_val(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_seq(string tag, int n);
        build_expect(n);
        for (int c = 0; c < n + 4; c++) begin
            @(negedge clk);
            check_val(tag, $sformatf("out_valid cycle %0d", c), longint'(out_valid), longint'(ex_v[c]));
            for (int m = 0; m < 4; m++) begin
                longint er, ei;
                er = ex_v[c] ? ex_re[c][m] : 0;
                ei = ex_v[c] ? ex_im[c][m] : 0;
                check_val(tag, $sformatf("re leg%0d cycle %0d", m, c), longint'($signed(out_re[m])), er);
                check_val(tag, $sformatf("im leg%0d cycle %0d", m, c), longint'($signed(out_im[m])), ei);
            end
            if (c < n) begin
                in_valid  = st_v[c];
                in_bypass = st_b[c];
                in_twidx  = KW'(st_k[c]);
                for (int m = 0; m < 4; m++) begin
                    in_re[m] = DW'(st_re[c][m]);
                    in_im[m] = DW'(st_im[c][m]);
                end
            end else begin
                in_valid  = 1'b0;
                in_bypass = 1'b1;
                in_twidx  = 6'd37;
                in_re     = '1;
                in_im     = '1;
            end
        end
    endtask

    task automatic set_group(int i, bit v, bit b, int k, int salt);
        st_v[i] = v;
        st_b[i] = b;
        st_k[i] = k;
        for (int m = 0; m < 4; m++) begin
            st_re[i][m] = ((i * 37 + m * 91 + salt) % 4000) - 2000;
            st_im[i][m] = ((i * 53 + m * 29 + salt * 3) % 3900) - 1950;
        end
    endtask

    // R9: reset state
    task automatic t_reset();
        @(negedge clk);
        check_val("R9 reset", "out_valid", longint'(out_valid), 0);
        check_val("R9 reset", "out_re", longint'(out_re), 0);
        rst_n = 1'b1;
    endtask

    // R1 R2 R3: butterfly values through the bypass path, with gaps
    task automatic t_bypass_formula();
        for (int i = 0; i < 8; i++) set_group(i, (i % 3) != 2, 1'b1, i * 5, 11);
        run_seq("R1 R2 R3 R9 bypass", 8);
    endtask

    // R7: full-scale inputs without adder wrap
    task automatic t_extremes();
        for (int i = 0; i < 4; i++) set_group(i, 1'b1, 1'b1, 0, 0);
        for (int m = 0; m < 4; m++) begin
            st_re[0][m] = -2048; st_im[0][m] = -2048;
            st_re[1][m] = 2047;  st_im[1][m] = -2048;
            st_re[2][m] = (m % 2 == 0) ? 2047 : -2048;
            st_im[2][m] = (m < 2) ? -2048 : 2047;
            st_re[3][m] = (m == 1) ? 2047 : -2048;
            st_im[3][m] = (m == 3) ? -2048 : 2047;
        end
        run_seq("R7 extremes", 4);
    endtask

    // R4 R5: rotation for a spread of indices, isolated groups
    task automatic t_twiddle();
        int ks[6] = '{1, 5, 16, 21, 42, 63};
        for (int i = 0; i < 12; i++) set_group(i, (i % 2) == 0, 1'b0, ks[i / 2], 7);
        run_seq("R4 R5 twiddle", 12);
    endtask

    // R6: k = 0 and k = 32 (legs 2 land on exponent 0)
    task automatic t_zero_exp();
        set_group(0, 1'b1, 1'b0, 0, 3);
        set_group(1, 1'b0, 1'b0, 0, 3);
        set_group(2, 1'b1, 1'b0, 32, 19);
        run_seq("R6 unit exponent", 3);
    endtask

    // R10 R11: back-to-back groups, index changing every clock
    task automatic t_stream();
        for (int i = 0; i < 16; i++) set_group(i, 1'b1, 1'b0, (i * 13 + 3) % N, 23);
        run_seq("R10 R11 stream", 16);
    endtask

    // R8: clash between rotated and bypassed group, isolated and in a mix
    task automatic t_clash();
        set_group(0, 1'b1, 1'b0, 9, 31);
        set_group(1, 1'b1, 1'b1, 9, 41);
        set_group(2, 1'b0, 1'b0, 0, 0);
        set_group(3, 1'b0, 1'b0, 0, 0);
        for (int i = 4; i < 14; i++) set_group(i, 1'b1, (i % 3) == 1, (i * 7) % N, 5);
        run_seq("R8 clash", 14);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_bypass_formula();
        t_extremes();
        t_twiddle();
        t_zero_exp();
        t_stream();
        t_clash();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule